// File: doc/BRIEF.md
# Five-Level Rectified-Sine Multicarrier Gate Generator

This block drives the five power switches of a reduced-switch, single-phase, five-level inverter. It builds a sampled sine reference inside the block. The reference comes from a phase accumulator and a quarter-wave table. The block splits the reference into a half-cycle sign and a rectified magnitude, and scales the magnitude by a 10-bit modulation-index word. It then compares that magnitude against two stacked triangular carriers. The carriers share one phase and are locked to the reference.

Which switch each comparison drives depends on the half cycle. The fifth gate is active only while neither of the two modulated gates is high. In operation, software or a slow control loop sets the modulation index and the carrier-to-reference frequency ratio. It then raises the enable input. Dropping enable forces every gate low and rewinds the reference and the carrier to zero phase.

The half cycle is tracked by a three-state machine:
- IDLE: no switching.
- POSITIVE: first half of the reference period.
- NEGATIVE: second half of the reference period.

The transitions are:
- start: IDLE to POSITIVE, when enable is seen high.
- to_neg: POSITIVE to NEGATIVE, when the next table index enters the upper half.
- to_pos: NEGATIVE to POSITIVE, when the index wraps back to the lower half.
- stop: POSITIVE or NEGATIVE to IDLE, when enable is low.

Top module: `mlpwm5_gategen`

## Requirements
- R1: `sw_gate` bit 0 is S1, bit 1 is S2, bit 2 is S3, bit 3 is S4 and bit 4 is S5. While `rst_n` is low, all five bits are 0. They are also 0 on every clock edge that samples `en` low, and 0 on the first edge that samples `en` high.
- R2: In the POSITIVE state, S4 is 1 and S2 is 0. S1 is 1 when the magnitude is strictly above the upper carrier. S3 is 1 when the magnitude is strictly below the lower carrier.
- R3: In the NEGATIVE state, S2 is 1 and S4 is 0. S1 is 1 when the magnitude is strictly below the lower carrier. S3 is 1 when the magnitude is strictly above the upper carrier.
- R4: While running, S5 equals NOT(S1 OR S3).
- R5: S1 and S3 are never 1 together, and S2 and S4 are never 1 together.
- R6: Carrier timing:
  - The carrier step count c runs from 0 to 127 and then wraps.
  - The lower carrier is 8*c for c below 64, and 8*(127-c) otherwise.
  - The upper carrier is the lower carrier plus 512.
- R7: Reference sampling. Let t be the count of running steps since start, and let P = ratio*128.
  - The table index is floor(t*256/P) mod 256.
  - Indices 128 and above are the NEGATIVE half.
  - With h = index mod 128, the quarter sample is q = h for h below 64, and q = 127-h otherwise.
  - The sine is about 1023*sin(pi*(2q+1)/256).
  - The magnitude is (sine*mod_index)>>10.
- R8: A `freq_ratio` of 0 or 1 is treated as 2.
- R9: With `mod_index` at or below 511, the upper carrier is never exceeded. S1 stays 0 in POSITIVE and S3 stays 0 in NEGATIVE, giving three-level output.
- R10: After start, the gates shown after the (n+2)th enabled edge reflect step t=n. Re-enabling restarts at t=0, so each reference period holds exactly `freq_ratio` carrier periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low forces gates low and rewinds phase |
| mod_index | input | 10 | Modulation index, 1023 is full scale |
| freq_ratio | input | 8 | Carrier periods per reference period |
| sw_gate | output | 5 | Gate bits S1..S5 (bit 0 = S1) |

## Verification
A half-cycle change (to_neg or to_pos) can fall in the same cycle as a carrier wrap at step zero. This happens whenever `freq_ratio` is even. On that edge, the routing of both comparisons to switches swaps at the same moment as the carriers restart from zero.

This is provoked by runs with ratios 18, 30, 100 and the clamped ratio 2. Each gate sample is judged against an independent real-valued sine model. Samples where the magnitude lies within a few codes of a carrier keep only the half-cycle, complement and exclusivity checks. A second coincidence occurs when enable is dropped: the stop transition and the last computed step share an edge. The bench checks that step's gates first and then an all-low output.

// File: rtl/mlpwm5_pkg.sv
package mlpwm5_pkg;

    localparam int AMP_W  = 10;   // magnitude / carrier code width
    localparam int TBL_W  = 8;    // full-period table index width
    localparam int QTR_W  = 6;    // quarter-wave address width
    localparam int QTR_N  = 1 << QTR_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_POS  = 2'd1,
        ST_NEG  = 2'd2
    } half_state_e;

    // Quarter-wave sample q (of QTR_N), centred at (q+0.5)/QTR_N of a quarter,
    // using an odd fifth-order polynomial in fixed point.
    function automatic logic [AMP_W-1:0] quarter_sine(input int q);
        longint u;
        longint u3;
        longint u5;
        longint num;
        longint val;
        u   = longint'(2 * q + 1);
        u3  = u * u * u;
        u5  = u3 * u * u;
        num = 64'sd15708 * u * (64'sd1 <<< 28)
            - 64'sd6460 * u3 * (64'sd1 <<< 14)
            + 64'sd797 * u5;
        val = (num * 64'sd1023) / (64'sd10000 <<< 35);
        if (val > 64'sd1023) val = 64'sd1023;
        if (val < 64'sd0)    val = 64'sd0;
        return val[AMP_W-1:0];
    endfunction

endpackage

// File: rtl/mlpwm5_carrier.sv
module mlpwm5_carrier #(
    parameter int HALF = 64,
    parameter int AW   = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [AW-1:0] car_lo,
    output logic [AW-1:0] car_hi
);
    localparam int CW   = $clog2(2 * HALF);
    localparam int STEP = (1 << (AW - 1)) / HALF;
    localparam int LAST = 2 * HALF - 1;

    logic [CW-1:0]   cnt;
    logic [CW-2:0]   fold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= (cnt == CW'(LAST)) ? '0 : cnt + 1'b1;
        end
    end

    always_comb begin
        fold   = cnt[CW-1] ? ~cnt[CW-2:0] : cnt[CW-2:0];
        car_lo = AW'(fold) * AW'(STEP);
        car_hi = car_lo + AW'(1 << (AW - 1));
    end

endmodule

// File: rtl/mlpwm5_phase.sv
module mlpwm5_phase
    import mlpwm5_pkg::*;
#(
    parameter int HALF = 64,
    parameter int RW   = 8,
    parameter int AW   = AMP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    input  logic [RW-1:0] ratio,
    input  logic [AW-1:0] mi,
    output logic          half_nxt,
    output logic [AW-1:0] mag
);
    localparam int CW    = $clog2(2 * HALF);
    localparam int PW    = RW + CW + 1;
    localparam int TBL_N = 1 << TBL_W;

    logic [PW-1:0]    acc;
    logic [PW-1:0]    period;
    logic [PW-1:0]    sum;
    logic [RW-1:0]    rat_eff;
    logic [TBL_W-1:0] idx;
    logic [TBL_W-1:0] idx_nxt;
    logic             wrap;
    logic [QTR_W-1:0] qa;
    logic [AMP_W-1:0] sine;
    logic [AMP_W+AW-1:0] prod;
    logic [AMP_W-1:0] qrom [QTR_N];

    for (genvar g = 0; g < QTR_N; g++) begin : g_rom
        assign qrom[g] = quarter_sine(g);
    end

    always_comb begin
        rat_eff = (ratio < RW'(2)) ? RW'(2) : ratio;
        period  = PW'(rat_eff) << CW;
        sum     = acc + PW'(TBL_N);
        wrap    = (sum >= period);
        idx_nxt = wrap ? idx + 1'b1 : idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            idx <= '0;
        end else if (clr) begin
            acc <= '0;
            idx <= '0;
        end else if (adv) begin
            acc <= wrap ? sum - period : sum;
            idx <= idx_nxt;
        end
    end

    assign half_nxt = adv ? idx_nxt[TBL_W-1] : idx[TBL_W-1];

    always_comb begin
        qa   = idx[TBL_W-2] ? ~idx[QTR_W-1:0] : idx[QTR_W-1:0];
        sine = qrom[qa];
        prod = (AMP_W+AW)'(sine) * (AMP_W+AW)'(mi);
        mag  = AW'(prod >> AMP_W);
    end

endmodule

// File: rtl/mlpwm5_gate_fsm.sv
module mlpwm5_gate_fsm
    import mlpwm5_pkg::*;
#(
    parameter int AW = AMP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          half_nxt,
    input  logic [AW-1:0] mag,
    input  logic [AW-1:0] car_lo,
    input  logic [AW-1:0] car_hi,
    output logic          run,
    output logic [4:0]    sw_gate
);
    half_state_e st;
    half_state_e st_nxt;
    logic        above;
    logic        below;

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: if (en) st_nxt = ST_POS;
            ST_POS:  if (!en) st_nxt = ST_IDLE;
                     else if (half_nxt) st_nxt = ST_NEG;
            ST_NEG:  if (!en) st_nxt = ST_IDLE;
                     else if (!half_nxt) st_nxt = ST_POS;
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    assign run   = en && (st != ST_IDLE);
    assign above = (mag > car_hi);
    assign below = (mag < car_lo);

    // bit 0 S1, 1 S2, 2 S3, 3 S4, 4 S5
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_gate <= '0;
        end else if (!en) begin
            sw_gate <= '0;
        end else begin
            unique case (st)
                ST_POS:  sw_gate <= {~(above | below), 1'b1, below, 1'b0, above};
                ST_NEG:  sw_gate <= {~(above | below), 1'b0, above, 1'b1, below};
                default: sw_gate <= '0;
            endcase
        end
    end

    // R5
    gate13_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_gate[0] && sw_gate[2]));

    // R5
    gate24_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_gate[1] && sw_gate[3]));

    // R1
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (sw_gate == 5'd0));

endmodule

// File: rtl/mlpwm5_gategen.sv
module mlpwm5_gategen
    import mlpwm5_pkg::*;
#(
    parameter int CAR_HALF = 64,
    parameter int RATIO_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [AMP_W-1:0]   mod_index,
    input  logic [RATIO_W-1:0] freq_ratio,
    output logic [4:0]         sw_gate
);
    logic             run;
    logic             half_nxt;
    logic [AMP_W-1:0] mag;
    logic [AMP_W-1:0] car_lo;
    logic [AMP_W-1:0] car_hi;

    mlpwm5_carrier #(.HALF(CAR_HALF), .AW(AMP_W)) u_car (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!en),
        .adv    (run),
        .car_lo (car_lo),
        .car_hi (car_hi)
    );

    mlpwm5_phase #(.HALF(CAR_HALF), .RW(RATIO_W), .AW(AMP_W)) u_ph (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!en),
        .adv      (run),
        .ratio    (freq_ratio),
        .mi       (mod_index),
        .half_nxt (half_nxt),
        .mag      (mag)
    );

    mlpwm5_gate_fsm #(.AW(AMP_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .half_nxt (half_nxt),
        .mag      (mag),
        .car_lo   (car_lo),
        .car_hi   (car_hi),
        .run      (run),
        .sw_gate  (sw_gate)
    );

    // R9
    three_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_index <= AMP_W'(511)) |-> !(mag > car_hi));

endmodule

// File: tb/mlpwm5_gategen_tb.sv
`timescale 1ns/1ps
module mlpwm5_gategen_tb;

    typedef struct {
        bit         zero;
        bit         full;
        bit         lvl3;
        logic [4:0] exp;
        int         t;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       en;
    logic [9:0] mod_index;
    logic [7:0] freq_ratio;
    logic [4:0] sw_gate;

    int    nchk = 0;
    int    nfail = 0;
    bit    done = 0;
    item_t sb[$];

    always #2.5 clk = ~clk;

    mlpwm5_gategen u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .mod_index  (mod_index),
        .freq_ratio (freq_ratio),
        .sw_gate    (sw_gate)
    );

    task automatic chk(input bit ok, input string req, input int t,
                       input logic [4:0] act, input logic [4:0] expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s t=%0d actual=%b expected=%b", req, t, act, expv);
        end
    endtask

    // Reference model from R2, R3, R6, R7, R8
    function automatic item_t model(input int t, input int m, input int r, input string tg);
        item_t  it;
        longint p;
        int     idx, h, q, c, lo, hi;
        real    mr;
        bit     ab, bl, neg;
        p   = longint'((r < 2) ? 2 : r) * 128;
        idx = int'((longint'(t) * 256 / p) % 256);
        neg = (idx >= 128);
        h   = idx % 128;
        q   = (h < 64) ? h : 127 - h;
        mr  = 1023.0 * $sin(3.14159265358979 * real'(2 * q + 1) / 256.0) * real'(m) / 1024.0;
        c   = t % 128;
        lo  = (c < 64) ? c * 8 : (127 - c) * 8;
        hi  = lo + 512;
        ab  = (mr > real'(hi));
        bl  = (mr < real'(lo));
        it.zero = 0;
        it.full = !((mr - real'(lo) < 4.0 && real'(lo) - mr < 4.0) ||
                    (mr - real'(hi) < 4.0 && real'(hi) - mr < 4.0));
        it.lvl3 = (m <= 511);
        it.t    = t;
        it.tag  = tg;
        if (!neg) it.exp = {~(ab | bl), 1'b1, bl, 1'b0, ab};
        else      it.exp = {~(ab | bl), 1'b0, ab, 1'b1, bl};
        return it;
    endfunction

    function automatic item_t zero_item(input string tg);
        item_t it;
        it.zero = 1; it.full = 1; it.lvl3 = 0; it.exp = '0; it.t = -1; it.tag = tg;
        return it;
    endfunction

    // driver: stimulus plus expected items
    task automatic run_case(input int m, input int r, input int n, input string tg);
        @(posedge clk); #1;
        mod_index  = 10'(m);
        freq_ratio = 8'(r);
        en         = 1'b1;
        sb.push_back(zero_item({"R1 idle ", tg}));
        sb.push_back(zero_item({"R1 R10 start ", tg}));
        for (int t = 0; t < n; t++) sb.push_back(model(t, m, r, tg));
        while (sb.size() > 0) @(posedge clk);
        #1;
        en = 1'b0;
        sb.push_back(model(n, m, r, tg));
        sb.push_back(zero_item({"R1 stop ", tg}));
        sb.push_back(zero_item({"R1 idle ", tg}));
        while (sb.size() > 0) @(posedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n === 1'b1 && sb.size() > 0) begin
            item_t it;
            logic  s1, s2, s3, s4, s5;
            it = sb.pop_front();
            {s5, s4, s3, s2, s1} = sw_gate;
            if (it.zero) begin
                chk(sw_gate == 5'd0, it.tag, it.t, sw_gate, 5'd0);
            end else begin
                // R2 R3: half-cycle legs
                chk(s2 == it.exp[1] && s4 == it.exp[3],
                    {(it.exp[3] ? "R2" : "R3"), " R7 R10 legs ", it.tag}, it.t, sw_gate, it.exp);
                // R4
                chk(s5 == ~(s1 | s3), {"R4 ", it.tag}, it.t, sw_gate, it.exp);
                // R5
                chk(!(s1 && s3) && !(s2 && s4), {"R5 ", it.tag}, it.t, sw_gate, it.exp);
                if (it.full)
                    chk(s1 == it.exp[0] && s3 == it.exp[2],
                        {(it.exp[3] ? "R2" : "R3"), " R6 R7 compare ", it.tag}, it.t, sw_gate, it.exp);
                if (it.lvl3)
                    chk(it.exp[3] ? !s1 : !s3, {"R9 three-level ", it.tag}, it.t, sw_gate, it.exp);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        rst_n      = 1'b0;
        en         = 1'b1;
        mod_index  = 10'd1023;
        freq_ratio = 8'd18;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(sw_gate == 5'd0, "R1 reset", -1, sw_gate, 5'd0);
        @(posedge clk); #1;
        en    = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(sw_gate == 5'd0, "R1 disabled", -1, sw_gate, 5'd0);
        run_case(0,    18, 2400,  "R10 mi0");
        run_case(400,  15, 2000,  "R9 mi400");
        run_case(1023, 30, 3900,  "R7 mi1023");
        run_case(700,  100, 12900, "R6 mi700");
        run_case(900,  0,  600,   "R8 ratio0");
        run_case(1023, 1,  300,   "R8 ratio1");
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule